// File: doc/BRIEF.md
# DDR SDRAM Command Decoder Monitor

This block watches the control pins of a DDR SDRAM interface and, on every rising clock edge, turns the sampled pin state into a named command. The pins it watches are chip select, the row strobe, the column strobe, write enable, clock enable, the bank bits and the address bus. It keeps a small model of the memory's bank state: which banks hold an open row, which row each holds, and whether the last accepted burst was a read that can still be cut short. With that history it can flag sequences that a plain pin decoder cannot see, such as a read to a closed bank or a burst terminate after a write.

Each sampled cycle produces one registered result one clock later. The result holds the command code, the bank and the row, column or op-code, the auto-precharge bit, a one-cycle violation pulse and its reason code. The open-bank bitmap and a row readback port give the tracked state. A separate write-beat path reports whether a write data beat is committed or masked. Commands that are flagged leave the bank model untouched, so the monitor keeps following the controller after a fault.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With chip select high the cycle decodes as NOP (code 0). With chip select low and row strobe, column strobe and write enable all high, it also decodes as NOP. Clock enable plays no part in either case, and neither case changes any state.
- R2: With chip select low, the active-low {ras_n,cas_n,we_n} patterns decode as follows. 011 is activate (1), 101 is read (2), 100 is write (3) and 110 is burst terminate (4). 010 is precharge: code 5 for one bank and code 6 for all banks. 001 is refresh and 000 is mode register set. The result is visible on the outputs one clock after the edge that sampled the pins.
- R3: The refresh pattern gives auto refresh (7) when clock enable is high and self refresh entry (8) when it is low. Any other non-NOP command sampled with clock enable low gives code 12 and reason 1. For code 12, bank and address read zero and no state changes.
- R4: For read and write, the address output is the column from addr[9:0] with the upper bits zero, and the auto-precharge output is addr[10]. A read or write to a bank with no open row gives reason 4.
- R5: Activate stores all twelve address bits as the row of the selected bank and marks that bank open. Activate to a bank that is already open gives reason 5, and the stored row stays unchanged.
- R6: Precharge with addr[10] low closes only the bank on the bank bits and reports it (code 5). This is legal even when that bank is already closed. With addr[10] high it closes every bank, reports code 6 and bank 0, and ignores the bank bits.
- R7: Mode register set with bank bits 00 gives code 9 and with bank bits 01 gives code 10. Bank bits 10 or 11 give code 11 and reason 2. In all three cases the address output carries the twelve-bit op-code and the bank output carries the bank bits.
- R8: Burst terminate is legal only when the last accepted burst was a read with addr[10] low and no burst terminate has been sampled since. Otherwise it gives reason 3: after reset, after a write, after an auto-precharge read, or on a second terminate.
- R9: An accepted read or write with addr[10] high closes its bank in the same edge that registers the command.
- R10: Auto refresh or self refresh entry while any bank is open gives reason 6.
- R11: viol is high for exactly the cycle that reports a flagged command, and viol_code is 0 whenever viol is low. Reset clears the bitmap, the burst history and all outputs. Flagged commands change no bank or burst state, except that any burst terminate ends the read burst.
- R12: beat_commit is high one clock after a cycle in which wbeat is high and dm is low. A high dm blocks that beat.
- R13: row_out shows, without a clock delay, the row stored for the bank chosen by row_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | 2 | Bank bits |
| addr | input | 12 | Address bus |
| wbeat | input | 1 | A write data beat is present this cycle |
| dm | input | 1 | Data mask for that beat |
| row_sel | input | 2 | Bank picked for row readback |
| cmd_code | output | 4 | Decoded command code |
| cmd_bank | output | 2 | Bank of the command, zero where unused |
| cmd_addr | output | 12 | Row, column or op-code, zero where unused |
| cmd_auto_pre | output | 1 | Auto-precharge bit of a read or write |
| open_map | output | 4 | One bit per bank, set while a row is open |
| row_out | output | 12 | Stored row of bank row_sel |
| viol | output | 1 | Protocol-violation pulse |
| viol_code | output | 3 | Reason for the violation |
| beat_commit | output | 1 | The previous write beat was committed |

## Verification
Two kinds of result can land in one registered cycle. The first is the closing of a bank by an auto-precharge read or write. The second is the judgment on the burst-terminate window that the same read opens or shuts. The bench provokes this with an auto-precharge read followed at once by a terminate. It expects the bitmap to drop the bank on the read's cycle and the terminate on the next cycle to be flagged. The write-beat mask path runs alongside command decode in the same cycles. It is judged by giving a write command a committed beat and a rejected terminate a masked beat.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [3:0] {
    C_NOP  = 4'd0,
    C_ACT  = 4'd1,
    C_RD   = 4'd2,
    C_WR   = 4'd3,
    C_BST  = 4'd4,
    C_PRE  = 4'd5,
    C_PREA = 4'd6,
    C_REF  = 4'd7,
    C_SREF = 4'd8,
    C_MRS  = 4'd9,
    C_EMRS = 4'd10,
    C_MRSX = 4'd11,
    C_ILL  = 4'd12
  } cmd_e;

  typedef enum logic [2:0] {
    W_NONE    = 3'd0,
    W_CKE     = 3'd1,
    W_MRS     = 3'd2,
    W_BST     = 3'd3,
    W_CLOSED  = 3'd4,
    W_REOPEN  = 3'd5,
    W_REFOPEN = 3'd6
  } why_e;

endpackage

// File: rtl/sdram_pin_decode.sv
module sdram_pin_decode
  import sdram_mon_pkg::*;
#(
  parameter int BA_W = 2
) (
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic            cke,
  input  logic            ap_bit,
  input  logic [BA_W-1:0] ba,
  output cmd_e            cmd
);

  cmd_e base;

  always_comb begin
    base = C_NOP;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b111:  base = C_NOP;
        3'b011:  base = C_ACT;
        3'b101:  base = C_RD;
        3'b100:  base = C_WR;
        3'b110:  base = C_BST;
        3'b010:  base = ap_bit ? C_PREA : C_PRE;
        3'b001:  base = cke ? C_REF : C_SREF;
        default: begin
          if (ba == BA_W'(0))      base = C_MRS;
          else if (ba == BA_W'(1)) base = C_EMRS;
          else                     base = C_MRSX;
        end
      endcase
    end
  end

  // Clock enable low is allowed only for NOP and self refresh entry
  always_comb begin
    if (!cke && base != C_NOP && base != C_SREF) cmd = C_ILL;
    else                                         cmd = base;
  end

endmodule

// File: rtl/sdram_rule_check.sv
module sdram_rule_check
  import sdram_mon_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int BA_W  = $clog2(BANKS)
) (
  input  cmd_e             cmd,
  input  logic [BA_W-1:0]  ba,
  input  logic [BANKS-1:0] open_vec,
  input  logic             rd_live,
  output why_e             why
);

  logic bank_open;
  logic any_open;

  assign bank_open = open_vec[ba];
  assign any_open  = |open_vec;

  always_comb begin
    why = W_NONE;
    case (cmd)
      C_ILL:         why = W_CKE;
      C_MRSX:        why = W_MRS;
      C_BST:         if (!rd_live)  why = W_BST;
      C_RD, C_WR:    if (!bank_open) why = W_CLOSED;
      C_ACT:         if (bank_open) why = W_REOPEN;
      C_REF, C_SREF: if (any_open)  why = W_REFOPEN;
      default:       why = W_NONE;
    endcase
  end

endmodule

// File: rtl/sdram_bank_state.sv
module sdram_bank_state #(
  parameter int BANKS = 4,
  parameter int ROW_W = 12,
  parameter int BA_W  = $clog2(BANKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BANKS-1:0] act_vec,
  input  logic [BANKS-1:0] close_vec,
  input  logic [ROW_W-1:0] row_in,
  input  logic [BA_W-1:0]  rd_sel,
  output logic [BANKS-1:0] open_vec,
  output logic [ROW_W-1:0] row_rd
);

  logic [ROW_W-1:0] row_q [BANKS];

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    logic open_q, open_d, open_en;

    assign open_en = act_vec[g] | close_vec[g];
    assign open_d  = act_vec[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       open_q <= 1'b0;
      else if (open_en) open_q <= open_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          row_q[g] <= '0;
      else if (act_vec[g]) row_q[g] <= row_in;
    end

    assign open_vec[g] = open_q;
  end

  assign row_rd = row_q[rd_sel];

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int ADDR_W = 12,
  parameter int COL_W  = 10,
  parameter int AP_BIT = 10,
  localparam int BA_W  = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              cke,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wbeat,
  input  logic              dm,
  input  logic [BA_W-1:0]   row_sel,
  output logic [3:0]        cmd_code,
  output logic [BA_W-1:0]   cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_auto_pre,
  output logic [BANKS-1:0]  open_map,
  output logic [ADDR_W-1:0] row_out,
  output logic              viol,
  output logic [2:0]        viol_code,
  output logic              beat_commit
);

  cmd_e             cmd;
  why_e             why;
  logic             accept;
  logic             ap;
  logic [BANKS-1:0] bank_1h;
  logic [BANKS-1:0] act_vec, close_vec;
  logic             rd_live_q, rd_live_d;

  cmd_e              cmd_q, cmd_d;
  why_e              why_q;
  logic [BA_W-1:0]   bank_q, bank_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              ap_q, ap_d;
  logic              commit_q, commit_d;

  assign ap      = addr[AP_BIT];
  assign bank_1h = BANKS'(1) << ba;

  sdram_pin_decode #(.BA_W(BA_W)) u_decode (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cke   (cke),
    .ap_bit(ap),
    .ba    (ba),
    .cmd   (cmd)
  );

  sdram_rule_check #(.BANKS(BANKS), .BA_W(BA_W)) u_rules (
    .cmd     (cmd),
    .ba      (ba),
    .open_vec(open_map),
    .rd_live (rd_live_q),
    .why     (why)
  );

  assign accept = (why == W_NONE);

  // Bank model updates, only for accepted commands
  always_comb begin
    act_vec   = '0;
    close_vec = '0;
    if (accept) begin
      case (cmd)
        C_ACT:      act_vec   = bank_1h;
        C_PRE:      close_vec = bank_1h;
        C_PREA:     close_vec = '1;
        C_RD, C_WR: if (ap) close_vec = bank_1h;
        default:    close_vec = '0;
      endcase
    end
  end

  sdram_bank_state #(.BANKS(BANKS), .ROW_W(ADDR_W), .BA_W(BA_W)) u_banks (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_vec  (act_vec),
    .close_vec(close_vec),
    .row_in   (addr),
    .rd_sel   (row_sel),
    .open_vec (open_map),
    .row_rd   (row_out)
  );

  // Read-burst window for burst terminate
  always_comb begin
    rd_live_d = rd_live_q;
    if (cmd == C_BST)                  rd_live_d = 1'b0;
    else if (accept && cmd == C_RD)    rd_live_d = !ap;
    else if (accept && cmd == C_WR)    rd_live_d = 1'b0;
  end

  // Reported fields
  always_comb begin
    cmd_d    = cmd;
    bank_d   = '0;
    addr_d   = '0;
    ap_d     = 1'b0;
    commit_d = wbeat & ~dm;
    case (cmd)
      C_ACT: begin
        bank_d = ba;
        addr_d = addr;
      end
      C_RD, C_WR: begin
        bank_d = ba;
        addr_d = ADDR_W'(addr[COL_W-1:0]);
        ap_d   = ap;
      end
      C_PRE: bank_d = ba;
      C_MRS, C_EMRS, C_MRSX: begin
        bank_d = ba;
        addr_d = addr;
      end
      default: begin
        bank_d = '0;
        addr_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_live_q <= 1'b0;
      cmd_q     <= C_NOP;
      why_q     <= W_NONE;
      bank_q    <= '0;
      addr_q    <= '0;
      ap_q      <= 1'b0;
      commit_q  <= 1'b0;
    end else begin
      rd_live_q <= rd_live_d;
      cmd_q     <= cmd_d;
      why_q     <= why;
      bank_q    <= bank_d;
      addr_q    <= addr_d;
      ap_q      <= ap_d;
      commit_q  <= commit_d;
    end
  end

  assign cmd_code     = cmd_q;
  assign cmd_bank     = bank_q;
  assign cmd_addr     = addr_q;
  assign cmd_auto_pre = ap_q;
  assign viol_code    = why_q;
  assign viol         = (why_q != W_NONE);
  assign beat_commit  = commit_q;

endmodule

// File: rtl/sdram_cmd_monitor_sva.sv
module sdram_cmd_monitor_sva
  import sdram_mon_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int BA_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       cmd_code,
  input logic [BA_W-1:0]  cmd_bank,
  input logic             cmd_auto_pre,
  input logic [BANKS-1:0] open_map,
  input logic             viol,
  input logic [2:0]       viol_code,
  input logic             wbeat,
  input logic             dm,
  input logic             beat_commit
);

  a_r11_code_when_flag: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> viol_code != 3'd0);

  a_r11_quiet_when_clean: assert property (@(posedge clk) disable iff (!rst_n)
    !viol |-> viol_code == 3'd0);

  a_r6_all_closed: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_code == C_PREA |-> open_map == '0);

  a_r5_reopen_keeps_map: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == C_ACT && viol) |-> open_map == $past(open_map));

  a_r4_burst_needs_row: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_code == C_RD || cmd_code == C_WR) && !viol)
      |-> (($past(open_map) >> cmd_bank) & BANKS'(1)) != '0);

  a_r9_ap_closes: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_code == C_RD || cmd_code == C_WR) && cmd_auto_pre && !viol)
      |-> ((open_map >> cmd_bank) & BANKS'(1)) == '0);

  a_r10_refresh_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_code == C_REF || cmd_code == C_SREF) && !viol) |-> $past(open_map) == '0);

  a_r3_cke_low_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_code == C_ILL |-> (viol && viol_code == W_CKE && $stable(open_map)));

  a_r12_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    beat_commit |-> $past(wbeat && !dm));

endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_sva #(.BANKS(BANKS), .BA_W(BA_W)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_code    (cmd_code),
  .cmd_bank    (cmd_bank),
  .cmd_auto_pre(cmd_auto_pre),
  .open_map    (open_map),
  .viol        (viol),
  .viol_code   (viol_code),
  .wbeat       (wbeat),
  .dm          (dm),
  .beat_commit (beat_commit)
);

// File: tb/sdram_cmd_monitor_tb.sv
`timescale 1ns/1ps
module sdram_cmd_monitor_tb;

  localparam logic [3:0] P_DES = 4'b1000;
  localparam logic [3:0] P_NOP = 4'b0111;
  localparam logic [3:0] P_ACT = 4'b0011;
  localparam logic [3:0] P_RD  = 4'b0101;
  localparam logic [3:0] P_WR  = 4'b0100;
  localparam logic [3:0] P_BST = 4'b0110;
  localparam logic [3:0] P_PRE = 4'b0010;
  localparam logic [3:0] P_REF = 4'b0001;
  localparam logic [3:0] P_MRS = 4'b0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, ras_n, cas_n, we_n, cke;
  logic [1:0]  ba;
  logic [11:0] addr;
  logic        wbeat, dm;
  logic [1:0]  row_sel;
  logic [3:0]  cmd_code;
  logic [1:0]  cmd_bank;
  logic [11:0] cmd_addr;
  logic        cmd_auto_pre;
  logic [3:0]  open_map;
  logic [11:0] row_out;
  logic        viol;
  logic [2:0]  viol_code;
  logic        beat_commit;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  typedef struct {
    logic [3:0]  code;
    logic [1:0]  bank;
    logic [11:0] addr;
    logic        ap;
    logic [3:0]  map;
    logic [2:0]  why;
    logic        commit;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #4 clk = ~clk;

  sdram_cmd_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .ba(ba), .addr(addr), .wbeat(wbeat), .dm(dm),
    .row_sel(row_sel), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .cmd_auto_pre(cmd_auto_pre), .open_map(open_map),
    .row_out(row_out), .viol(viol), .viol_code(viol_code),
    .beat_commit(beat_commit)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: compares one expectation per registered result
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check({e.tag, " code"},   32'(cmd_code),     32'(e.code));
      check({e.tag, " bank"},   32'(cmd_bank),     32'(e.bank));
      check({e.tag, " addr"},   32'(cmd_addr),     32'(e.addr));
      check({e.tag, " ap"},     32'(cmd_auto_pre), 32'(e.ap));
      check({e.tag, " map"},    32'(open_map),     32'(e.map));
      check({e.tag, " viol"},   32'(viol),         32'(e.why != 3'd0));
      check({e.tag, " reason"}, 32'(viol_code),    32'(e.why));
      check({e.tag, " commit"}, 32'(beat_commit),  32'(e.commit));
    end
  end

  task automatic drive(input logic [3:0] pins, input logic ck, input logic [1:0] b,
                       input logic [11:0] a, input logic bt, input logic m);
    {cs_n, ras_n, cas_n, we_n} = pins;
    cke = ck; ba = b; addr = a; wbeat = bt; dm = m;
  endtask

  // Driver: one command per cycle, expectation pushed to the scoreboard
  task automatic step(input logic [3:0] pins, input logic ck, input logic [1:0] b,
                      input logic [11:0] a, input logic bt, input logic m,
                      input logic [3:0] code, input logic [1:0] eb, input logic [11:0] ea,
                      input logic eap, input logic [3:0] emap, input logic [2:0] ewhy,
                      input logic ecommit, input string tag);
    exp_t e;
    @(negedge clk);
    drive(pins, ck, b, a, bt, m);
    e.code = code; e.bank = eb; e.addr = ea; e.ap = eap; e.map = emap;
    e.why = ewhy; e.commit = ecommit; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic row_check(input logic [1:0] sel, input logic [11:0] exp, input string tag);
    @(negedge clk);
    drive(P_NOP, 1'b1, 2'd0, 12'h000, 1'b0, 1'b0);
    row_sel = sel;
    #1;
    check(tag, 32'(row_out), 32'(exp));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    row_sel = 2'd0;
    drive(P_NOP, 1'b1, 2'd0, 12'h000, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R11 reset code",  32'(cmd_code), 0);
    check("R11 reset map",   32'(open_map), 0);
    check("R11 reset viol",  32'(viol), 0);
    check("R11 reset reason",32'(viol_code), 0);

    step(P_DES, 1, 2'd3, 12'hFFF, 0, 0, 0, 0, 12'h000, 0, 4'b0000, 0, 0, "R1 deselect");
    step(P_NOP, 1, 2'd2, 12'hABC, 0, 0, 0, 0, 12'h000, 0, 4'b0000, 0, 0, "R1 nop");
    step(P_ACT, 1, 2'd1, 12'hABC, 0, 0, 1, 1, 12'hABC, 0, 4'b0010, 0, 0, "R5 activate b1");
    row_check(2'd1, 12'hABC, "R13 row b1");
    step(P_ACT, 1, 2'd1, 12'h123, 0, 0, 1, 1, 12'h123, 0, 4'b0010, 5, 0, "R5 reopen");
    row_check(2'd1, 12'hABC, "R5 row kept");
    step(P_RD,  1, 2'd2, 12'h005, 0, 0, 2, 2, 12'h005, 0, 4'b0010, 4, 0, "R4 read closed");
    step(P_BST, 1, 2'd0, 12'h000, 0, 0, 4, 0, 12'h000, 0, 4'b0010, 3, 0, "R8 bst no burst");
    step(P_RD,  1, 2'd1, 12'hBFF, 0, 0, 2, 1, 12'h3FF, 0, 4'b0010, 0, 0, "R4 read column");
    step(P_BST, 1, 2'd0, 12'h000, 0, 0, 4, 0, 12'h000, 0, 4'b0010, 0, 0, "R8 bst legal");
    step(P_BST, 1, 2'd0, 12'h000, 0, 0, 4, 0, 12'h000, 0, 4'b0010, 3, 0, "R8 bst twice");
    step(P_WR,  1, 2'd1, 12'h007, 1, 0, 3, 1, 12'h007, 0, 4'b0010, 0, 1, "R12 write beat kept");
    step(P_BST, 1, 2'd0, 12'h000, 1, 1, 4, 0, 12'h000, 0, 4'b0010, 3, 0, "R8 R12 bst after write masked");
    step(P_ACT, 1, 2'd0, 12'hFFF, 0, 0, 1, 0, 12'hFFF, 0, 4'b0011, 0, 0, "R5 activate b0");
    step(P_RD,  1, 2'd0, 12'h410, 0, 0, 2, 0, 12'h010, 1, 4'b0010, 0, 0, "R9 ap read closes");
    step(P_BST, 1, 2'd0, 12'h000, 0, 0, 4, 0, 12'h000, 0, 4'b0010, 3, 0, "R8 bst after ap read");
    step(P_REF, 1, 2'd0, 12'h000, 0, 0, 7, 0, 12'h000, 0, 4'b0010, 6, 0, "R10 refresh open");
    step(P_PRE, 1, 2'd1, 12'h000, 0, 0, 5, 1, 12'h000, 0, 4'b0000, 0, 0, "R6 precharge b1");
    step(P_ACT, 1, 2'd3, 12'h005, 0, 0, 1, 3, 12'h005, 0, 4'b1000, 0, 0, "R5 activate b3");
    step(P_ACT, 1, 2'd2, 12'h009, 0, 0, 1, 2, 12'h009, 0, 4'b1100, 0, 0, "R5 activate b2");
    row_check(2'd3, 12'h005, "R13 row b3");
    row_check(2'd2, 12'h009, "R13 row b2");
    step(P_PRE, 1, 2'd1, 12'h000, 0, 0, 5, 1, 12'h000, 0, 4'b1100, 0, 0, "R6 precharge closed bank");
    step(P_PRE, 1, 2'd1, 12'h400, 0, 0, 6, 0, 12'h000, 0, 4'b0000, 0, 0, "R6 precharge all");
    step(P_REF, 1, 2'd0, 12'h000, 0, 0, 7, 0, 12'h000, 0, 4'b0000, 0, 0, "R2 R3 auto refresh");
    step(P_REF, 0, 2'd0, 12'h000, 0, 0, 8, 0, 12'h000, 0, 4'b0000, 0, 0, "R3 self refresh");
    step(P_ACT, 0, 2'd2, 12'h077, 0, 0, 12, 0, 12'h000, 0, 4'b0000, 1, 0, "R3 cke low act");
    step(P_MRS, 1, 2'd0, 12'h032, 0, 0, 9, 0, 12'h032, 0, 4'b0000, 0, 0, "R7 base mode");
    step(P_MRS, 1, 2'd1, 12'h001, 0, 0, 10, 1, 12'h001, 0, 4'b0000, 0, 0, "R7 ext mode");
    step(P_MRS, 1, 2'd2, 12'h044, 0, 0, 11, 2, 12'h044, 0, 4'b0000, 2, 0, "R7 reserved 10");
    step(P_MRS, 1, 2'd3, 12'h055, 0, 0, 11, 3, 12'h055, 0, 4'b0000, 2, 0, "R7 reserved 11");
    step(P_NOP, 1, 2'd0, 12'h000, 0, 0, 0, 0, 12'h000, 0, 4'b0000, 0, 0, "R11 pulse ends");
    step(P_WR,  1, 2'd0, 12'h003, 0, 0, 3, 0, 12'h003, 0, 4'b0000, 4, 0, "R4 write closed");
    step(P_ACT, 1, 2'd2, 12'h00A, 0, 0, 1, 2, 12'h00A, 0, 4'b0100, 0, 0, "R5 activate b2 again");
    step(P_WR,  1, 2'd2, 12'h404, 0, 0, 3, 2, 12'h004, 1, 4'b0000, 0, 0, "R9 ap write closes");
    step(P_RD,  1, 2'd2, 12'h001, 0, 0, 2, 2, 12'h001, 0, 4'b0000, 4, 0, "R9 read after ap");
    step(P_DES, 0, 2'd0, 12'h000, 0, 0, 0, 0, 12'h000, 0, 4'b0000, 0, 0, "R1 deselect cke low");

    @(negedge clk);
    drive(P_NOP, 1'b1, 2'd0, 12'h000, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check("scoreboard drained", 32'(sb.size()), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule